// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block watches a general-purpose input port, 16 bits wide by default. It raises an active-low interrupt request whenever the port differs from a stored reference snapshot. The port pins arrive asynchronously. They pass through a two-stage synchronizer, and the synchronized value is compared with the snapshot. Any level change on any pin therefore asserts the request. If the pins go back to the snapshot value, the request releases by itself.

The local serial bus slave supplies a few qualifiers: this device is selected, the access is a read, the current bit is the acknowledge slot, and one-cycle strobes mark the rising and falling edges of the serial clock. A completed read clears and re-arms the request on the rising clock edge of its acknowledge bit. A completed write does the same on the falling edge. On a clear, the snapshot reloads from the current synchronized port value, so the next change is detected as a new interrupt. Traffic for other slaves leaves the request alone.

The output is a pull-low enable for an open-drain pad. When it is 1 the pad pulls the line low; when it is 0 the line is released. The block has no way to drive the line high.

Top module: `port_change_irq`

## Requirements
- R1: While reset is high, and after reset with the pins held stable through it, irq_pull_low is 0. The snapshot equals the synchronized port value.
- R2: A rise or a fall on any single pin, or on several pins at once, sets irq_pull_low to 1 on the third rising clk edge after the change is sampled. It is still 0 after the second edge.
- R3: If the pins return to the snapshot value with no bus clear, irq_pull_low goes back to 0 on the third clk edge after the return.
- R4: A clock edge with slv_selected=1, slv_read=1, slv_ack_slot=1 and scl_rise_evt=1 clears irq_pull_low to 0 after that edge. The snapshot takes the current synchronized value.
- R5: A clock edge with slv_selected=1, slv_read=0, slv_ack_slot=1 and scl_fall_evt=1 clears the request in the same way. scl_rise_evt during a write does not clear, and neither does scl_fall_evt during a read.
- R6: While slv_selected=0, no strobe changes the request or the snapshot.
- R7: With slv_ack_slot=0, no strobe changes the request or the snapshot.
- R8: After a clear, a new change of the pins relative to the reloaded snapshot raises the request again with the R2 latency.
- R9: A change whose synchronized value reaches the comparator in the same cycle as a clear is absorbed into the snapshot and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| port_pins | input | WIDTH | Asynchronous general-purpose port inputs |
| slv_selected | input | 1 | Bus slave: the current transfer addresses this device |
| slv_read | input | 1 | Bus slave: 1 for a read access, 0 for a write access |
| slv_ack_slot | input | 1 | Bus slave: the current bit is the acknowledge bit |
| scl_rise_evt | input | 1 | One-cycle strobe on a rising serial clock edge |
| scl_fall_evt | input | 1 | One-cycle strobe on a falling serial clock edge |
| irq_pull_low | output | 1 | 1 pulls the open-drain interrupt line low, 0 releases it |

## Verification
The assertions check four things on every cycle. The request is released after reset. It is released one cycle after a qualified read or write clear. It never rises unless the synchronized port value changed. It holds while the port is stable and no clear arrives. The bench's scenarios are needed to show the exact three-edge latency and the self-release when the pins return to the snapshot. They also show that the wrong clock edge, a deselected device or a strobe outside the acknowledge slot is ignored, that a change arriving in the clear cycle is absorbed, and that the next change after a clear is detected again.

// File: rtl/pcig_pkg.sv
package pcig_pkg;

    // Qualifiers delivered by the local serial bus slave.
    typedef struct packed {
        logic selected;
        logic read;
        logic ack_slot;
        logic rise;
        logic fall;
    } bus_evt_t;

    typedef enum logic [1:0] {
        CLR_NONE  = 2'd0,
        CLR_READ  = 2'd1,
        CLR_WRITE = 2'd2
    } clear_src_e;

    // A read clears on the rising clock edge of its acknowledge bit;
    // a write clears on the falling one.
    function automatic clear_src_e clear_source(bus_evt_t ev);
        clear_src_e src;
        src = CLR_NONE;
        if (ev.selected && ev.ack_slot) begin
            if (ev.read && ev.rise) begin
                src = CLR_READ;
            end else if (!ev.read && ev.fall) begin
                src = CLR_WRITE;
            end
        end
        return src;
    endfunction

endpackage

// File: rtl/pcig_sync.sv
module pcig_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];

    // No reset: the chain keeps sampling during reset so that the
    // snapshot can be loaded from a settled value.
    always_ff @(posedge clk) begin
        stg[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[LAST];
endmodule

// File: rtl/pcig_clear_ctl.sv
module pcig_clear_ctl
    import pcig_pkg::*;
(
    input  bus_evt_t   evt,
    output clear_src_e src,
    output logic       clr
);
    always_comb begin
        src = clear_source(evt);
        clr = (src != CLR_NONE);
    end
endmodule

// File: rtl/pcig_change_det.sv
module pcig_change_det #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] sync_val,
    input  logic             clr,
    output logic             irq
);
    logic [WIDTH-1:0] snap;
    logic [WIDTH-1:0] diff;

    assign diff = sync_val ^ snap;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            snap <= sync_val;
            irq  <= 1'b0;
        end else begin
            irq  <= |diff;
        end
    end
endmodule

// File: rtl/port_change_irq.sv
module port_change_irq
    import pcig_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] port_pins,
    input  logic             slv_selected,
    input  logic             slv_read,
    input  logic             slv_ack_slot,
    input  logic             scl_rise_evt,
    input  logic             scl_fall_evt,
    output logic             irq_pull_low
);
    logic [WIDTH-1:0] sync_val;
    bus_evt_t         evt;
    clear_src_e       clr_src;
    logic             clr;

    assign evt = '{selected: slv_selected, read: slv_read,
                   ack_slot: slv_ack_slot, rise: scl_rise_evt,
                   fall: scl_fall_evt};

    pcig_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (port_pins),
        .dout (sync_val)
    );

    pcig_clear_ctl u_clr (
        .evt (evt),
        .src (clr_src),
        .clr (clr)
    );

    pcig_change_det #(.WIDTH(WIDTH)) u_det (
        .clk      (clk),
        .rst      (rst),
        .sync_val (sync_val),
        .clr      (clr),
        .irq      (irq_pull_low)
    );
endmodule

// File: rtl/pcig_checker.sv
module pcig_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] port_pins,
    input logic             slv_selected,
    input logic             slv_read,
    input logic             slv_ack_slot,
    input logic             scl_rise_evt,
    input logic             scl_fall_evt,
    input logic             irq_pull_low
);
    // Cycles since reset, saturating; guards the $past look-backs.
    // The look-back depths assume the default two synchronizer stages.
    logic [2:0] age;
    always_ff @(posedge clk) begin
        if (rst) age <= 3'd0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    a_r1_reset_released: assert property (@(posedge clk)
        rst |=> !irq_pull_low);

    a_r4_read_clear: assert property (@(posedge clk) disable iff (rst)
        (slv_selected && slv_ack_slot && slv_read && scl_rise_evt)
        |=> !irq_pull_low);

    a_r5_write_clear: assert property (@(posedge clk) disable iff (rst)
        (slv_selected && slv_ack_slot && !slv_read && scl_fall_evt)
        |=> !irq_pull_low);

    a_r2_rise_needs_change: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd4 && !irq_pull_low && !$past(rst)) |=>
        (!irq_pull_low || ($past(port_pins, 3) != $past(port_pins, 4))));

    a_r6_hold_without_clear: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd4 && irq_pull_low && !slv_selected &&
         $past(port_pins, 2) == $past(port_pins, 3))
        |=> irq_pull_low);
endmodule

bind port_change_irq pcig_checker #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .port_pins    (port_pins),
    .slv_selected (slv_selected),
    .slv_read     (slv_read),
    .slv_ack_slot (slv_ack_slot),
    .scl_rise_evt (scl_rise_evt),
    .scl_fall_evt (scl_fall_evt),
    .irq_pull_low (irq_pull_low)
);

// File: tb/tb_port_change_irq.sv
module tb_port_change_irq;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] pins = 16'hA5C3;
    logic         sel = 1'b0, rd = 1'b0, ack = 1'b0, rise = 1'b0, fall = 1'b0;
    logic         irq;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_change_irq #(.WIDTH(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .port_pins(pins),
        .slv_selected(sel), .slv_read(rd), .slv_ack_slot(ack),
        .scl_rise_evt(rise), .scl_fall_evt(fall),
        .irq_pull_low(irq)
    );

    // Behavioural reference: history of sampled pins, a snapshot, an expectation.
    logic [W-1:0] hist[$];
    logic [W-1:0] m_snap = '0;
    logic         m_irq  = 1'b0;
    bit           m_valid = 1'b0;

    always @(posedge clk) begin
        logic [W-1:0] synced;
        bit           clr_now;
        synced  = (hist.size() >= 2) ? hist[hist.size()-2] : pins;
        clr_now = sel && ack && ((rd && rise) || (!rd && fall));
        if (rst || clr_now) begin
            m_irq  = 1'b0;
            m_snap = synced;
        end else begin
            m_irq  = (synced != m_snap);
        end
        hist.push_back(pins);
        if (hist.size() > 4) void'(hist.pop_front());
        m_valid = 1'b1;
    end

    task automatic check(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_pull_low actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model at every falling edge.
    always @(negedge clk) begin
        if (m_valid && !done) check(cur_req, irq, m_irq);
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe(logic s, logic r, logic a, logic ri, logic fa);
        sel = s; rd = r; ack = a; rise = ri; fall = fa;
        @(negedge clk);
        sel = 1'b0; rd = 1'b0; ack = 1'b0; rise = 1'b0; fall = 1'b0;
    endtask

    initial begin
        cyc(6);
        check("R1", irq, 1'b0);
        rst = 1'b0;
        cyc(4);
        check("R1", irq, 1'b0);

        // R2: single rising bit, latency of three edges
        cur_req = "R2";
        pins = 16'hA5C3 | 16'h0004;
        cyc(2); check("R2", irq, 1'b0);
        cyc(1); check("R2", irq, 1'b1);
        // R3: return to snapshot releases by itself
        cur_req = "R3";
        pins = 16'hA5C3;
        cyc(2); check("R3", irq, 1'b1);
        cyc(1); check("R3", irq, 1'b0);
        cyc(3);

        // R2: falling top bit
        cur_req = "R2";
        pins = 16'h25C3;
        cyc(3); check("R2", irq, 1'b1);
        cyc(2);

        // R4: read clear on rising edge of acknowledge
        cur_req = "R4";
        strobe(1, 1, 1, 1, 0);
        check("R4", irq, 1'b0);
        cyc(5); check("R4", irq, 1'b0);

        // R8: next change detected again (multi-bit)
        cur_req = "R8";
        pins = 16'h25C3 ^ 16'h0F00;
        cyc(3); check("R8", irq, 1'b1);

        // R5: wrong edges ignored, then write clear on falling edge
        cur_req = "R5";
        strobe(1, 0, 1, 1, 0);
        check("R5", irq, 1'b1);
        strobe(1, 1, 1, 0, 1);
        check("R5", irq, 1'b1);
        strobe(1, 0, 1, 0, 1);
        check("R5", irq, 1'b0);
        cyc(3);

        // R8: returning to the old value now differs from the new snapshot
        cur_req = "R8";
        pins = 16'h25C3;
        cyc(3); check("R8", irq, 1'b1);

        // R6: deselected device ignored
        cur_req = "R6";
        strobe(0, 1, 1, 1, 0);
        check("R6", irq, 1'b1);
        strobe(0, 0, 1, 0, 1);
        cyc(2); check("R6", irq, 1'b1);

        // R7: strobes outside acknowledge slot ignored
        cur_req = "R7";
        strobe(1, 1, 0, 1, 0);
        check("R7", irq, 1'b1);
        strobe(1, 0, 0, 0, 1);
        cyc(2); check("R7", irq, 1'b1);
        strobe(1, 1, 1, 1, 0);
        check("R4", irq, 1'b0);
        cyc(3);

        // R9: change reaching comparator in the clear cycle is absorbed
        cur_req = "R9";
        pins = 16'h25C3 ^ 16'h8001;
        cyc(2);
        strobe(1, 1, 1, 1, 0);
        check("R9", irq, 1'b0);
        cyc(6); check("R9", irq, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule